// File: doc/BRIEF.md
# Self-Gated Digital Charge Integrator

This block takes a stream of unsigned ADC samples from a photomultiplier or silicon photomultiplier and does the work of a discriminator, a gate generator and a charge-to-digital converter. A timing filter finds each pulse. The filter smooths the signal over two samples and subtracts a copy of itself taken a programmable number of samples earlier. When the filter output rises strictly above a threshold, the block fires a gate. A delay line on the integration path lets that gate start a programmable number of samples before the trigger point, so the leading edge of the pulse is included.

While the gate is open, the block subtracts a pedestal from each delayed sample and adds the result to a long-gate charge. A shorter gate, which starts at the same trigger, adds the same values to a short-gate charge, for pulse-shape discrimination. The pedestal is a block mean of the delayed stream taken over a power-of-two number of samples. When the long gate closes, both charges and a timestamp are presented together with a one-cycle valid strobe. The block has no conversion dead time: a new gate can open on the first edge after the previous one closes.

A polarity input inverts the samples before any processing, so negative pulses are handled in the same way as positive ones. All arithmetic is signed, so bipolar pulses integrate to their net charge.

Top module: `selfgate_charge_int`

## Requirements
- R1: Let x(n) be the polarity-corrected sample with index n. The filter value is f(n) = x(n) + x(n-1) - x(n-r) - x(n-r-1), where r = rise_i + 1. The trigger sample T is a sample with f(T) > thr_i, compared as signed values with strict inequality.
- R2: The long charge is the sum of (x - pedestal) over the samples T-delay_i through T-delay_i+Wl-1. Wl is long_w_i, and a value of 0 counts as 1.
- R3: The pedestal is the mean of 2^base_log2_i consecutive delayed samples. It is computed as a block sum shifted right and is updated when each block completes.
- R4: The pedestal sum and the pedestal value do not change on any clock edge at which the gate is open or opening.
- R5: A trigger condition that occurs while a gate is open is ignored, so each gate produces exactly one event.
- R6: evt_valid_o is high for exactly one cycle, on the cycle after the edge that takes the last long-gate term. The charge and time outputs keep their values until the next event.
- R7: evt_time_o is the index of the trigger sample T. The sample captured on the first clock edge after reset is released has index 0.
- R8: The short charge sums the first min(short_w_i, Wl) terms of the long gate. A short_w_i of 0 gives a short charge of 0.
- R9: With neg_pol_i = 1 every sample is negated before filtering, pedestal and integration, so a downward pulse gives a positive charge. Bipolar pulses integrate to their signed net charge.
- R10: During reset, evt_valid_o, both charges and evt_time_o are 0.
- R11: The charge registers hold a full-scale sample times the maximum gate width (4095 x 255 at the default sizes) without overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_i | input | DW | Unsigned ADC sample, one per clock |
| neg_pol_i | input | 1 | 1 inverts the sample polarity |
| thr_i | input | DW+1 | Trigger threshold on the filter output |
| rise_i | input | RLW | Derivative span minus one |
| delay_i | input | DLW | Pre-gate delay in samples |
| base_log2_i | input | BLW | Log2 of the pedestal block length |
| long_w_i | input | WLW | Long gate width in samples |
| short_w_i | input | WLW | Short gate width in samples |
| evt_valid_o | output | 1 | One-cycle event strobe |
| evt_qlong_o | output | DW+2+WLW | Signed long-gate charge |
| evt_qshort_o | output | DW+2+WLW | Signed short-gate charge |
| evt_time_o | output | TSW | Trigger sample index |

## Verification
Sample T is seen by the filter on edge T+1, and the gate takes its Wl terms on edges T+1 through T+Wl. The event registers are loaded on edge T+Wl, so the strobe and the values are visible from that cycle's falling edge. The bench drives samples on falling edges and numbers them itself. It records every strobe that it sees on a falling edge, so it never guesses at a fixed latency. After each pulse it waits longer than the delay plus the gate width plus the pulse length before it compares the single recorded event with the hand-computed charges and the expected sample index.

// File: rtl/selfgate_charge_int.sv
`timescale 1ns/1ps
module selfgate_charge_int #(
  parameter int DW  = 12,
  parameter int DLW = 4,
  parameter int RLW = 3,
  parameter int WLW = 8,
  parameter int BLW = 3,
  parameter int TSW = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DW-1:0]                samp_i,
  input  logic                         neg_pol_i,
  input  logic [DW:0]                  thr_i,
  input  logic [RLW-1:0]               rise_i,
  input  logic [DLW-1:0]               delay_i,
  input  logic [BLW-1:0]               base_log2_i,
  input  logic [WLW-1:0]               long_w_i,
  input  logic [WLW-1:0]               short_w_i,
  output logic                         evt_valid_o,
  output logic signed [DW+WLW+1:0]     evt_qlong_o,
  output logic signed [DW+WLW+1:0]     evt_qshort_o,
  output logic [TSW-1:0]               evt_time_o
);
  localparam int XW  = DW + 1;
  localparam int FW  = XW + 2;
  localparam int QW  = DW + WLW + 2;
  localparam int HD  = (1 << DLW) + (1 << RLW) + 1;
  localparam int HI  = $clog2(HD);
  localparam int BLM = (1 << BLW) - 1;
  localparam int SW  = XW + BLM;

  logic signed [XW-1:0] hist [HD];
  logic signed [XW-1:0] xin, dly, base;
  logic signed [FW-1:0] filt;
  logic signed [SW-1:0] bsum, bnext;
  logic [BLM-1:0]       bcnt, bmax;
  logic [HI-1:0]        ia, ib, id;
  logic signed [QW-1:0] term, acc_l, acc_s, nxt_l, nxt_s;
  logic [WLW-1:0]       k, kk, weff;
  logic [WLW:0]         kk1;
  logic                 open, trig, ingate, last, sen;
  logic [TSW-1:0]       tcount, tsh, tsnow;

  assign xin = neg_pol_i ? -$signed({1'b0, samp_i}) : $signed({1'b0, samp_i});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HD; i++) hist[i] <= '0;
    end else begin
      hist[0] <= xin;
      for (int i = 1; i < HD; i++) hist[i] <= hist[i-1];
    end
  end

  assign ia   = HI'(rise_i) + HI'(1);
  assign ib   = ia + HI'(1);
  assign id   = HI'(delay_i);
  assign filt = FW'(hist[0]) + FW'(hist[1]) - FW'(hist[ia]) - FW'(hist[ib]);
  assign dly  = hist[id];

  assign trig   = !open && (filt > $signed({2'b00, thr_i}));
  assign ingate = open || trig;
  assign kk     = open ? k : '0;
  assign kk1    = {1'b0, kk} + 1'b1;
  assign weff   = (long_w_i == '0) ? WLW'(1) : long_w_i;
  assign last   = ingate && (kk1 >= {1'b0, weff});
  assign sen    = kk < short_w_i;
  assign term   = QW'(dly) - QW'(base);
  assign nxt_l  = (open ? acc_l : '0) + term;
  assign nxt_s  = (open ? acc_s : '0) + (sen ? term : '0);
  assign tsnow  = open ? tsh : tcount - TSW'(1);

  assign bmax  = ~(~BLM'(0) << base_log2_i);
  assign bnext = bsum + SW'(dly);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0;
      bsum <= '0;
      bcnt <= '0;
    end else if (!ingate) begin
      if (bcnt == bmax) begin
        base <= XW'(bnext >>> base_log2_i);
        bsum <= '0;
        bcnt <= '0;
      end else begin
        bsum <= bnext;
        bcnt <= bcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open         <= 1'b0;
      k            <= '0;
      acc_l        <= '0;
      acc_s        <= '0;
      tcount       <= '0;
      tsh          <= '0;
      evt_valid_o  <= 1'b0;
      evt_qlong_o  <= '0;
      evt_qshort_o <= '0;
      evt_time_o   <= '0;
    end else begin
      tcount      <= tcount + 1'b1;
      evt_valid_o <= 1'b0;
      if (trig) tsh <= tcount - TSW'(1);
      if (ingate) begin
        acc_l <= nxt_l;
        acc_s <= nxt_s;
        k     <= WLW'(kk1);
        open  <= !last;
        if (last) begin
          evt_qlong_o  <= nxt_l;
          evt_qshort_o <= nxt_s;
          evt_time_o   <= tsnow;
          evt_valid_o  <= 1'b1;
        end
      end
    end
  end

  a_r4_base_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ingate |=> ($stable(base) && $stable(bsum)));

  a_r5_stamp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (open && !last) |=> $stable(tsh));

  a_r6_valid_after_gate: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid_o |-> $past(ingate));

  a_r2_open_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    open |-> ({1'b0, k} < {1'b0, weff}));

  a_r6_outputs_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(ingate && last) |=> ($stable(evt_qlong_o) && $stable(evt_time_o)));
endmodule

// File: tb/tb_selfgate_charge_int.sv
`timescale 1ns/1ps
module tb_selfgate_charge_int;
  localparam int QW = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] samp = '0;
  logic neg_pol = 1'b0;
  logic [12:0] thr = '0;
  logic [2:0] rise = '0;
  logic [3:0] dly = '0;
  logic [2:0] bl = 3'd3;
  logic [7:0] wl = 8'd1, ws = 8'd1;
  logic evt_valid;
  logic signed [QW-1:0] qlong, qshort;
  logic [31:0] etime;

  int n_chk = 0, n_bad = 0, idx = 0, nev = 0;
  longint lql = 0, lqs = 0, lts = 0;

  always #5 clk = ~clk;

  selfgate_charge_int dut (
    .clk(clk), .rst_n(rst_n), .samp_i(samp), .neg_pol_i(neg_pol), .thr_i(thr),
    .rise_i(rise), .delay_i(dly), .base_log2_i(bl), .long_w_i(wl), .short_w_i(ws),
    .evt_valid_o(evt_valid), .evt_qlong_o(qlong), .evt_qshort_o(qshort), .evt_time_o(etime)
  );

  typedef struct packed {
    int p; int pol; int h; int h2; int l; int th; int d; int rs;
    int wl; int ws; int bl; int toff; int ql; int qs;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{100,  0, 50,   0,  10, 30,  4, 1, 20,  6,  3, 0, 500, 100},
    '{200,  0, 50,   0,  12, 60,  3, 2,  8,  3,  3, 1, 300, 50},
    '{3000, 1, 100,  0,  5,  80,  0, 1,  4,  2,  2, 0, 400, 200},
    '{500,  0, 20,   0,  3,  10, 10, 1, 12, 12,  4, 0, 40,  40},
    '{0,    0, 70,   0,  4,  5,   1, 1,  3,  1,  3, 0, 140, 0},
    '{1000, 0, 10,   0,  20, 5,   2, 1,  5,  9,  3, 0, 30,  30},
    '{800,  0, 60, -60,  3,  40,  1, 1, 10,  4,  3, 0, 0,   180},
    '{0,    0, 4095, 0, 300, 100, 0, 1, 255, 255, 3, 0, 1044225, 1044225}
  };

  function automatic string vtag(input int i);
    case (i)
      1: return "R1 second-sample trigger";
      2: return "R9 negative polarity";
      3: return "R3 long pre-gate";
      4: return "R8 zero short";
      5: return "R8 short clipped";
      6: return "R9 bipolar";
      7: return "R11 full scale";
      default: return "R3 base";
    endcase
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int v);
    @(negedge clk);
    samp = 12'(v);
    idx++;
  endtask

  always @(negedge clk) begin
    if (rst_n && evt_valid) begin
      nev++;
      lql = qlong;
      lqs = qshort;
      lts = etime;
    end
  end

  function automatic int sval(input int p, input int pol, input int y);
    return pol != 0 ? p - y : p + y;
  endfunction

  task automatic set_cfg(input vec_t v);
    neg_pol = v.pol[0];
    thr = 13'(v.th);
    dly = 4'(v.d);
    rise = 3'(v.rs);
    wl = 8'(v.wl);
    ws = 8'(v.ws);
    bl = 3'(v.bl);
  endtask

  task automatic pulse(input vec_t v, output int s);
    s = idx;
    for (int i = 0; i < v.l; i++) drive(sval(v.p, v.pol, v.h));
    if (v.h2 != 0)
      for (int i = 0; i < v.l; i++) drive(sval(v.p, v.pol, v.h2));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset valid", longint'(evt_valid), 0);
    chk("R10 reset qlong", qlong, 0);
    chk("R10 reset qshort", qshort, 0);
    chk("R10 reset time", longint'(etime), 0);
    @(negedge clk);
    rst_n = 1'b1;
    samp = '0;
    idx = 1;

    for (int vi = 0; vi < 8; vi++) begin
      vec_t v;
      int s;
      v = VT[vi];
      set_cfg(v);
      repeat (150) drive(v.p);
      nev = 0;
      pulse(v, s);
      repeat (v.l * 2 + v.wl + v.d + 40) drive(v.p);
      $display("vector %0d: %s", vi, vtag(vi));
      chk("R5 R6 one event per gate", nev, 1);
      chk("R2 R3 long charge", lql, v.ql);
      chk("R8 short charge", lqs, v.qs);
      chk("R7 timestamp", lts, s + v.toff);
      chk("R6 outputs held", qlong, lql);
    end

    begin
      vec_t v;
      int s1, s2;
      v = VT[0];
      v.bl = 4;
      set_cfg(v);
      repeat (150) drive(v.p);
      nev = 0;
      pulse(v, s1);
      repeat (14) drive(v.p);
      pulse(v, s2);
      repeat (60) drive(v.p);
      chk("R4 two events", nev, 2);
      chk("R4 second long charge unpolluted", lql, 500);
      chk("R4 second short charge", lqs, 100);
      chk("R7 second timestamp", lts, s2);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule